// File: doc/BRIEF.md
# Atomic Lock Method Controller

This block sequences one indivisible read-modify-write on a lock variable. When a request arrives, it looks at the operand address, its size and whether the region is writeback-cacheable. From these it picks one of two methods. A cache lock runs the whole sequence inside the cache once the line is owned. A bus lock keeps the system bus held from the first read to the last write, so no other agent can get in between.

Each phase is a request/acknowledge pair to the surrounding logic: ownership, read, modify and write. A final unlock cycle reports completion. For a cache lock, the unlock cycle also publishes the new line state. A configuration input can force the bus method for every access.

Top module: `lock_ctrl`

## Requirements
- R1: A start with `wb_i`=1, `force_bus_i`=0 and an operand whose first byte `addr_i` and last byte `addr_i + 2**size_i - 1` lie in the same aligned 8-byte window and the same aligned 32-byte line selects the cache method, reported as `use_bus_o`=0. `size_i` encodes 1, 2, 4 or 8 bytes as 0..3.
- R2: A start with `wb_i`=0, or with an operand whose first and last bytes fall in different aligned 8-byte windows, selects the bus method (`use_bus_o`=1).
- R3: `force_bus_i`=1 at start selects the bus method regardless of address and cacheability.
- R4: The ownership request `own_req_o` is issued only under the cache method, and only when `line_state_i` sampled at start is Invalid (0) or Shared (1). For Exclusive (2) or Modified (3) it is skipped.
- R5: Under the bus method, `bus_lock_o` is high in every cycle in which a read, modify or write request is pending. It falls in the cycle after the write acknowledge. It is never high under the cache method or during ownership.
- R6: Requests appear in the order ownership, read, modify, write. At most one is high at a time, and each stays high until its acknowledge.
- R7: Under the cache method, the unlock cycle pulses `line_upd_o` with `line_state_o` = Modified (3). Under the bus method, `line_upd_o` stays low.
- R8: `done_o` pulses for one cycle, one cycle after the write acknowledge, and `busy_o` is low on the next cycle.
- R9: After reset, every request, `bus_lock_o`, `busy_o`, `done_o` and `line_upd_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a locked sequence (sampled when idle) |
| addr_i | input | AW | Operand byte address |
| size_i | input | 2 | Operand size, log2 of bytes |
| wb_i | input | 1 | Region is writeback-cacheable |
| force_bus_i | input | 1 | Always use the bus method |
| line_state_i | input | 2 | Current line state: 0 I, 1 S, 2 E, 3 M |
| own_req_o | output | 1 | Request line ownership |
| own_ack_i | input | 1 | Ownership granted |
| rd_req_o | output | 1 | Read request |
| rd_ack_i | input | 1 | Read done |
| mod_req_o | output | 1 | Modify request |
| mod_ack_i | input | 1 | Modify done |
| wr_req_o | output | 1 | Write request |
| wr_ack_i | input | 1 | Write done |
| bus_lock_o | output | 1 | System bus held locked |
| use_bus_o | output | 1 | Selected method: 1 bus, 0 cache |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Completion pulse |
| line_upd_o | output | 1 | Line state update strobe |
| line_state_o | output | 2 | New line state on update |

## Verification
The bench sweeps every start offset across two 32-byte lines, every operand size, both cacheability values, both force values and all four incoming line states. This puts aligned, 8-byte-crossing and line-crossing operands against each other under each attribute. Method errors are then separated from ownership-skip errors. Acknowledge latency alternates between zero and one wait cycle. This exposes a lock window that drops between phases and a request that does not hold while it waits.

// File: rtl/lock_pkg.sv
package lock_pkg;
  typedef enum logic [1:0] {LS_I = 2'd0, LS_S = 2'd1, LS_E = 2'd2, LS_M = 2'd3} line_st_e;
  typedef enum logic [2:0] {
    ST_IDLE, ST_OWN, ST_READ, ST_MOD, ST_WRITE, ST_UNLOCK
  } lk_state_e;
endpackage

// File: rtl/lock_method_sel.sv
module lock_method_sel #(
  parameter int AW          = 32,
  parameter int LINE_BYTES  = 32,
  parameter int SPLIT_BYTES = 8
) (
  input  logic [AW-1:0] addr_i,
  input  logic [1:0]    size_i,
  input  logic          wb_i,
  input  logic          force_bus_i,
  output logic          use_cache_o
);
  localparam int LINE_SH = $clog2(LINE_BYTES);
  localparam int SPL_SH  = $clog2(SPLIT_BYTES);

  logic [AW-1:0] span, last;
  logic          cross_split, cross_line;

  assign span        = (AW'(1) << size_i) - AW'(1);
  assign last        = addr_i + span;
  assign cross_split = (addr_i >> SPL_SH) != (last >> SPL_SH);
  assign cross_line  = (addr_i >> LINE_SH) != (last >> LINE_SH);
  assign use_cache_o = wb_i && !force_bus_i && !cross_split && !cross_line;
endmodule

// File: rtl/lock_seq_fsm.sv
module lock_seq_fsm
  import lock_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       use_cache_i,
  input  logic [1:0] line_state_i,
  input  logic       own_ack_i,
  input  logic       rd_ack_i,
  input  logic       mod_ack_i,
  input  logic       wr_ack_i,
  output logic       own_req_o,
  output logic       rd_req_o,
  output logic       mod_req_o,
  output logic       wr_req_o,
  output logic       bus_lock_o,
  output logic       use_bus_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       line_upd_o,
  output logic [1:0] line_state_o
);
  lk_state_e state_q, state_d;
  logic      bus_q;
  logic      need_own;

  // ownership needed unless line already E or M
  assign need_own = use_cache_i && (line_state_i < 2'(LS_E));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (start_i) state_d = need_own ? ST_OWN : ST_READ;
      ST_OWN:    if (own_ack_i) state_d = ST_READ;
      ST_READ:   if (rd_ack_i)  state_d = ST_MOD;
      ST_MOD:    if (mod_ack_i) state_d = ST_WRITE;
      ST_WRITE:  if (wr_ack_i)  state_d = ST_UNLOCK;
      ST_UNLOCK: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      bus_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && start_i) bus_q <= !use_cache_i;
    end
  end

  assign own_req_o    = state_q == ST_OWN;
  assign rd_req_o     = state_q == ST_READ;
  assign mod_req_o    = state_q == ST_MOD;
  assign wr_req_o     = state_q == ST_WRITE;
  assign bus_lock_o   = bus_q && (state_q inside {ST_READ, ST_MOD, ST_WRITE});
  assign use_bus_o    = bus_q;
  assign busy_o       = state_q != ST_IDLE;
  assign done_o       = state_q == ST_UNLOCK;
  assign line_upd_o   = done_o && !bus_q;
  assign line_state_o = line_upd_o ? 2'(LS_M) : 2'(LS_I);
endmodule

// File: rtl/lock_ctrl.sv
module lock_ctrl #(
  parameter int AW          = 32,
  parameter int LINE_BYTES  = 32,
  parameter int SPLIT_BYTES = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] addr_i,
  input  logic [1:0]    size_i,
  input  logic          wb_i,
  input  logic          force_bus_i,
  input  logic [1:0]    line_state_i,
  output logic          own_req_o,
  input  logic          own_ack_i,
  output logic          rd_req_o,
  input  logic          rd_ack_i,
  output logic          mod_req_o,
  input  logic          mod_ack_i,
  output logic          wr_req_o,
  input  logic          wr_ack_i,
  output logic          bus_lock_o,
  output logic          use_bus_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          line_upd_o,
  output logic [1:0]    line_state_o
);
  logic use_cache;

  lock_method_sel #(.AW(AW), .LINE_BYTES(LINE_BYTES), .SPLIT_BYTES(SPLIT_BYTES)) i_sel (
    .addr_i      (addr_i),
    .size_i      (size_i),
    .wb_i        (wb_i),
    .force_bus_i (force_bus_i),
    .use_cache_o (use_cache)
  );

  lock_seq_fsm i_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .use_cache_i  (use_cache),
    .line_state_i (line_state_i),
    .own_ack_i    (own_ack_i),
    .rd_ack_i     (rd_ack_i),
    .mod_ack_i    (mod_ack_i),
    .wr_ack_i     (wr_ack_i),
    .own_req_o    (own_req_o),
    .rd_req_o     (rd_req_o),
    .mod_req_o    (mod_req_o),
    .wr_req_o     (wr_req_o),
    .bus_lock_o   (bus_lock_o),
    .use_bus_o    (use_bus_o),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .line_upd_o   (line_upd_o),
    .line_state_o (line_state_o)
  );
endmodule

// File: rtl/lock_ctrl_chk.sv
module lock_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       own_req_o,
  input logic       rd_req_o,
  input logic       rd_ack_i,
  input logic       mod_req_o,
  input logic       wr_req_o,
  input logic       wr_ack_i,
  input logic       bus_lock_o,
  input logic       use_bus_o,
  input logic       busy_o,
  input logic       done_o,
  input logic       line_upd_o,
  input logic [1:0] line_state_o
);
  a_r6_one_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({own_req_o, rd_req_o, mod_req_o, wr_req_o}));

  a_r6_rd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && !rd_ack_i |=> rd_req_o);

  a_r4_own_unlocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    own_req_o |-> !bus_lock_o && !use_bus_o);

  a_r5_hold_to_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bus_lock_o) |-> $past(wr_req_o && wr_ack_i));

  a_r5_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_lock_o && wr_req_o && wr_ack_i |=> !bus_lock_o);

  a_r7_upd_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_upd_o |-> $past(wr_req_o && wr_ack_i) && line_state_o == 2'd3);

  a_r8_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
endmodule

bind lock_ctrl lock_ctrl_chk i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .own_req_o    (own_req_o),
  .rd_req_o     (rd_req_o),
  .rd_ack_i     (rd_ack_i),
  .mod_req_o    (mod_req_o),
  .wr_req_o     (wr_req_o),
  .wr_ack_i     (wr_ack_i),
  .bus_lock_o   (bus_lock_o),
  .use_bus_o    (use_bus_o),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .line_upd_o   (line_upd_o),
  .line_state_o (line_state_o)
);

// File: tb/test_lock_ctrl.sv
module test_lock_ctrl;
  localparam int AW = 32;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic start_i = 1'b0, wb_i = 1'b0, force_bus_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [1:0] size_i = '0, line_state_i = '0, line_state_o;
  logic own_ack_i = 0, rd_ack_i = 0, mod_ack_i = 0, wr_ack_i = 0;
  logic own_req_o, rd_req_o, mod_req_o, wr_req_o;
  logic bus_lock_o, use_bus_o, busy_o, done_o, line_upd_o;

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #5 clk_i = ~clk_i;

  lock_ctrl #(.AW(AW)) i_lock_ctrl (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 190000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic run_op(input int a, input int sz, input bit wb, input bit frc,
                        input int ls, input int lat);
    int  last, cnt, steps, prev, k;
    bit  exp_cache, saw_own, lock_bad, order_bad, done_seen, upd_seen;
    int  method_at_done, upd_state;
    last      = a + (1 << sz) - 1;
    exp_cache = wb && !frc && ((a >> 3) == (last >> 3)) && ((a >> 5) == (last >> 5));
    saw_own = 0; lock_bad = 0; order_bad = 0; done_seen = 0; upd_seen = 0;
    prev = -1; cnt = 0; steps = 0; method_at_done = -1; upd_state = 0;
    @(negedge clk_i);
    addr_i = AW'(32'h1000 + a); size_i = 2'(sz); wb_i = wb; force_bus_i = frc;
    line_state_i = 2'(ls); start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    while (!done_seen && steps < 40) begin
      k = own_req_o ? 0 : rd_req_o ? 1 : mod_req_o ? 2 : wr_req_o ? 3 : -1;
      if (own_req_o) saw_own = 1;
      if (k >= 0) begin
        if (k < prev) order_bad = 1;
        prev = k;
      end
      if ((rd_req_o || mod_req_o || wr_req_o) && bus_lock_o != !exp_cache) lock_bad = 1;
      if (own_req_o && bus_lock_o) lock_bad = 1;
      if ($countones({own_req_o, rd_req_o, mod_req_o, wr_req_o}) > 1) order_bad = 1;
      if (done_o) begin
        done_seen = 1;
        method_at_done = int'(use_bus_o);
        upd_seen = line_upd_o;
        upd_state = int'(line_state_o);
        if (bus_lock_o) lock_bad = 1;
        if (prev != 3) order_bad = 1;
      end
      if (k >= 0 && cnt >= lat) begin
        own_ack_i = own_req_o; rd_ack_i = rd_req_o;
        mod_ack_i = mod_req_o; wr_ack_i = wr_req_o;
        cnt = 0;
      end else begin
        own_ack_i = 0; rd_ack_i = 0; mod_ack_i = 0; wr_ack_i = 0;
        if (k >= 0) cnt++;
      end
      steps++;
      if (!done_seen) @(negedge clk_i);
    end
    own_ack_i = 0; rd_ack_i = 0; mod_ack_i = 0; wr_ack_i = 0;
    chk(done_seen, "R8 done seen", int'(done_seen), 1);
    if (frc)
      chk(method_at_done == 1, "R3 forced bus", method_at_done, 1);
    else if (exp_cache)
      chk(method_at_done == 0, "R1 cache method", method_at_done, 0);
    else
      chk(method_at_done == 1, "R2 bus method", method_at_done, 1);
    chk(saw_own == (exp_cache && ls < 2), "R4 ownership step", int'(saw_own),
        int'(exp_cache && ls < 2));
    chk(!lock_bad, "R5 lock window", int'(lock_bad), 0);
    chk(!order_bad, "R6 request order", int'(order_bad), 0);
    chk(upd_seen == exp_cache, "R7 line update", int'(upd_seen), int'(exp_cache));
    if (exp_cache) chk(upd_state == 3, "R7 modified state", upd_state, 3);
    @(negedge clk_i);
    chk(!busy_o && !done_o, "R8 idle after done", int'(busy_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk({own_req_o, rd_req_o, mod_req_o, wr_req_o, bus_lock_o, busy_o, done_o, line_upd_o} == 8'h0,
        "R9 reset outputs", int'({own_req_o, rd_req_o, mod_req_o, wr_req_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!busy_o && !bus_lock_o, "R9 idle after reset", int'(busy_o), 0);
    for (int a = 0; a < 64; a++)
      for (int sz = 0; sz < 4; sz++)
        for (int wb = 0; wb < 2; wb++)
          for (int frc = 0; frc < 2; frc++)
            for (int ls = 0; ls < 4; ls++)
              run_op(a, sz, bit'(wb), bit'(frc), ls, (a + ls + sz) % 2);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule